// File: doc/BRIEF.md
# Configurable Registered Command Buffer with Cascadable Parity

This block is a clocked register that sits on the command and address path of a memory module. On each rising clock edge it captures a parallel input word and presents it on registered outputs. Two static configuration pins choose one of two layouts. In the wide layout the block is a 25-lane one-to-one register. In the split layout it is a 14-lane register in which every captured lane drives two output bits. The split layout also tells the block whether it is the first or the second device of a two-device pair.

Alongside the data path, the block checks even parity over the module-independent data lanes and a parity bit from the controller. Failures are flagged on an active-low error output. In a pair, the first device forwards its partial parity on a dedicated output. The second device takes that bit in place of the controller's parity bit and makes the final decision. When both active-low chip-select inputs are high, the outputs and the parity pipeline keep their state. Chip-select inputs are module-dependent, so they take no part in the parity sum.

Top module: `cfg_regbuf`

## Requirements
- R1: While `rst` is high at a clock edge, `q_out` becomes all zeros, `err_n` becomes 1 and `ppar_out` becomes 0. They keep those values until new data is captured.
- R2: With `cfg_split` = 0 and a capture enabled, the edge loads `d_in[24:0]` into `q_out[24:0]`. `q_out[27:25]` stays 0.
- R3: A capture is enabled when at least one bit of `cs_n[1:0]` is 0 (a 0 bit selects the device).
- R4: When `cs_n` = 2'b11 at an edge, `q_out` keeps its value whatever `d_in` is. That edge also leaves nothing for the parity pipeline to report: `err_n` and `ppar_out` keep their value on the following edge.
- R5: With `cfg_split` = 1 and a capture enabled, the edge loads `d_in[13:0]` into both `q_out[13:0]` and `q_out[27:14]`. `d_in[24:14]` has no effect on any output.
- R6: With `cfg_split` = 0, one edge after a capture `err_n` is 0 if the count of ones in the captured `d_in[24:0]` plus `par_in` is odd, and 1 if it is even.
- R7: Where R6 updates `err_n`, `ppar_out` also updates on that edge. Its new value is the XOR of the captured active data lanes (`d_in[24:0]` in the wide layout, `d_in[13:0]` in the split layout) and `par_in`.
- R8: With `cfg_split` = 1 and `cfg_upper` = 0 (first device), `err_n` stays 1. Parity covers only `d_in[13:0]`, and the result is reported on `ppar_out` as in R7.
- R9: With `cfg_split` = 1 and `cfg_upper` = 1 (second device), `err_n` updates two edges after a capture. The new value is 0 if the XOR of the captured `d_in[13:0]` and the `ppar_in` sampled at that second edge is 1, and 1 otherwise. `par_in` is ignored.
- R10: With `cfg_split` = 0 the block behaves as in R2 and R6 whatever the value of `cfg_upper`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every capture happens on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfg_split | input | 1 | 0: 25-lane one-to-one layout; 1: 14-lane one-to-two layout |
| cfg_upper | input | 1 | In the split layout: 0 first device, 1 second device |
| cs_n | input | 2 | Active-low chip selects; capture when any bit is 0 |
| d_in | input | 25 | Module-independent data lanes |
| par_in | input | 1 | Even-parity bit from the controller |
| ppar_in | input | 1 | Partial parity from the partner device (second device only) |
| q_out | output | 28 | Registered data outputs |
| err_n | output | 1 | Parity error flag, active low |
| ppar_out | output | 1 | Partial parity to the partner device |

## Verification
The properties assume that `cfg_split` and `cfg_upper` change only while `rst` is high. The stimulus therefore picks a new layout only inside a reset sequence and holds it until the next one. The second-device property also assumes that `ppar_in` is settled at the edge where the final check is made. The stimulus sets that bit before the data word is captured and leaves it alone until the result has been read. All inputs change on the falling clock edge, so every sampled value is unambiguous.

// File: rtl/cfg_regbuf_pkg.sv
package cfg_regbuf_pkg;

  typedef enum logic [1:0] {
    ROLE_SINGLE = 2'd0,
    ROLE_FIRST  = 2'd1,
    ROLE_SECOND = 2'd2
  } role_e;

  function automatic role_e role_decode(input logic split, input logic upper);
    if (!split)     return ROLE_SINGLE;
    else if (!upper) return ROLE_FIRST;
    else            return ROLE_SECOND;
  endfunction

endpackage

// File: rtl/cfg_regbuf_fanout.sv
module cfg_regbuf_fanout #(
  parameter int W_WIDE   = 25,
  parameter int W_NARROW = 14,
  parameter int OUT_W    = 28
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en,
  input  logic              split,
  input  logic [W_WIDE-1:0] d_in,
  output logic [OUT_W-1:0]  q_out
);

  logic [OUT_W-1:0] nxt;

  // Each output lane picks its source for both layouts; the split layout
  // folds the upper half back onto the narrow input lanes.
  for (genvar i = 0; i < OUT_W; i++) begin : g_lane
    logic wide_b;
    logic split_b;
    if (i < W_WIDE) begin : g_w
      assign wide_b = d_in[i];
    end else begin : g_wz
      assign wide_b = 1'b0;
    end
    if (i < W_NARROW) begin : g_lo
      assign split_b = d_in[i];
    end else if (i < 2*W_NARROW) begin : g_hi
      assign split_b = d_in[i-W_NARROW];
    end else begin : g_sz
      assign split_b = 1'b0;
    end
    assign nxt[i] = split ? split_b : wide_b;
  end

  always_ff @(posedge clk) begin
    if (rst)         q_out <= '0;
    else if (cap_en) q_out <= nxt;
  end

endmodule

// File: rtl/cfg_regbuf_parity.sv
module cfg_regbuf_parity
  import cfg_regbuf_pkg::*;
#(
  parameter int W_WIDE   = 25,
  parameter int W_NARROW = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en,
  input  role_e             role,
  input  logic [W_WIDE-1:0] d_in,
  input  logic              par_in,
  input  logic              ppar_in,
  output logic              err_n,
  output logic              ppar_out
);

  logic [W_WIDE-1:0] lane_on;
  logic              data_par;

  // Narrow lanes always count; the rest only in the one-to-one layout.
  for (genvar i = 0; i < W_WIDE; i++) begin : g_mask
    if (i < W_NARROW) begin : g_on
      assign lane_on[i] = 1'b1;
    end else begin : g_sel
      assign lane_on[i] = (role == ROLE_SINGLE);
    end
  end

  assign data_par = ^(d_in & lane_on);

  logic s1_vld, s1_dpar, s1_par;
  logic s2_vld, s2_dpar;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld   <= 1'b0;
      s1_dpar  <= 1'b0;
      s1_par   <= 1'b0;
      s2_vld   <= 1'b0;
      s2_dpar  <= 1'b0;
      err_n    <= 1'b1;
      ppar_out <= 1'b0;
    end else begin
      s1_vld <= cap_en;
      if (cap_en) begin
        s1_dpar <= data_par;
        s1_par  <= par_in;
      end
      s2_vld  <= s1_vld && (role == ROLE_SECOND);
      s2_dpar <= s1_dpar;
      if (s1_vld) begin
        ppar_out <= s1_dpar ^ s1_par;
        if (role == ROLE_SINGLE) err_n <= ~(s1_dpar ^ s1_par);
      end
      if (s2_vld) err_n <= ~(s2_dpar ^ ppar_in);
    end
  end

endmodule

// File: rtl/cfg_regbuf.sv
module cfg_regbuf
  import cfg_regbuf_pkg::*;
#(
  parameter int W_WIDE   = 25,
  parameter int W_NARROW = 14,
  parameter int CS_W     = 2,
  localparam int OUT_W   = (W_WIDE > 2*W_NARROW) ? W_WIDE : 2*W_NARROW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_split,
  input  logic              cfg_upper,
  input  logic [CS_W-1:0]   cs_n,
  input  logic [W_WIDE-1:0] d_in,
  input  logic              par_in,
  input  logic              ppar_in,
  output logic [OUT_W-1:0]  q_out,
  output logic              err_n,
  output logic              ppar_out
);

  logic  cap_en;
  role_e role;

  assign cap_en = ~(&cs_n);
  assign role   = role_decode(cfg_split, cfg_upper);

  cfg_regbuf_fanout #(
    .W_WIDE(W_WIDE), .W_NARROW(W_NARROW), .OUT_W(OUT_W)
  ) u_fanout (
    .clk(clk), .rst(rst), .cap_en(cap_en), .split(cfg_split),
    .d_in(d_in), .q_out(q_out)
  );

  cfg_regbuf_parity #(
    .W_WIDE(W_WIDE), .W_NARROW(W_NARROW)
  ) u_parity (
    .clk(clk), .rst(rst), .cap_en(cap_en), .role(role),
    .d_in(d_in), .par_in(par_in), .ppar_in(ppar_in),
    .err_n(err_n), .ppar_out(ppar_out)
  );

endmodule

// File: rtl/cfg_regbuf_chk.sv
module cfg_regbuf_chk #(
  parameter int W_WIDE   = 25,
  parameter int W_NARROW = 14,
  parameter int CS_W     = 2,
  parameter int OUT_W    = 28
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_split,
  input logic              cfg_upper,
  input logic [CS_W-1:0]   cs_n,
  input logic [W_WIDE-1:0] d_in,
  input logic              par_in,
  input logic              ppar_in,
  input logic [OUT_W-1:0]  q_out,
  input logic              err_n,
  input logic              ppar_out
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (q_out == '0 && err_n && !ppar_out));

  assert_wide_capture_R2: assert property (@(posedge clk) disable iff (rst)
    (!cfg_split && !(&cs_n)) |=> q_out[W_WIDE-1:0] == $past(d_in));

  assert_wide_top_zero_R2: assert property (@(posedge clk) disable iff (rst)
    !cfg_split |-> (q_out >> W_WIDE) == '0);

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (&cs_n) |=> $stable(q_out));

  assert_mirror_R5: assert property (@(posedge clk) disable iff (rst)
    cfg_split |-> q_out[W_NARROW-1:0] == q_out[2*W_NARROW-1:W_NARROW]);

  assert_wide_parity_R6: assert property (@(posedge clk) disable iff (rst)
    (!cfg_split && !(&cs_n)) |=> ##1
      (err_n == !((^$past(d_in, 2)) ^ $past(par_in, 2))));

  assert_first_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (cfg_split && !cfg_upper) |-> err_n);

  assert_second_final_R9: assert property (@(posedge clk) disable iff (rst)
    (cfg_split && cfg_upper && !(&cs_n)) |=> ##2
      (err_n == !((^$past(d_in[W_NARROW-1:0], 3)) ^ $past(ppar_in))));

endmodule

bind cfg_regbuf cfg_regbuf_chk #(
  .W_WIDE(W_WIDE), .W_NARROW(W_NARROW), .CS_W(CS_W), .OUT_W(OUT_W)
) u_chk (
  .clk(clk), .rst(rst), .cfg_split(cfg_split), .cfg_upper(cfg_upper),
  .cs_n(cs_n), .d_in(d_in), .par_in(par_in), .ppar_in(ppar_in),
  .q_out(q_out), .err_n(err_n), .ppar_out(ppar_out)
);

// File: tb/cfg_regbuf_test.sv
module cfg_regbuf_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_split = 1'b0;
  logic        cfg_upper = 1'b0;
  logic [1:0]  cs_n = 2'b11;
  logic [24:0] d_in = '0;
  logic        par_in = 1'b0;
  logic        ppar_in = 1'b0;
  logic [27:0] q_out;
  logic        err_n;
  logic        ppar_out;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  cfg_regbuf uut (
    .clk(clk), .rst(rst), .cfg_split(cfg_split), .cfg_upper(cfg_upper),
    .cs_n(cs_n), .d_in(d_in), .par_in(par_in), .ppar_in(ppar_in),
    .q_out(q_out), .err_n(err_n), .ppar_out(ppar_out)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [24:0] d, input logic p, input logic [1:0] cs);
    d_in = d; par_in = p; cs_n = cs;
    @(negedge clk);
  endtask

  task automatic do_reset(input logic split, input logic upper);
    rst = 1'b1; cfg_split = split; cfg_upper = upper;
    cs_n = 2'b11; d_in = 25'h1ABCDEF; par_in = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 q during reset", q_out, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 q after reset", q_out, 0);
    check("R1 err_n after reset", err_n, 1);
    check("R1 ppar_out after reset", ppar_out, 0);
  endtask

  // One-to-one capture, then an unselected cycle that exposes the parity result.
  task automatic wide_case(input logic [24:0] d, input logic p, input logic [1:0] cs);
    logic [27:0] exp_q;
    exp_q = {3'b000, d};
    step(d, p, cs);
    check("R2/R3 wide capture", q_out, exp_q);
    step(~d, ~p, 2'b11);
    check("R4 q held while unselected", q_out, exp_q);
    check("R6 err_n one cycle after capture", err_n, !((^d) ^ p));
    check("R7 ppar_out wide", ppar_out, (^d) ^ p);
  endtask

  task automatic t_wide;
    do_reset(1'b0, 1'b0);
    wide_case(25'h0000000, 1'b0, 2'b10);
    wide_case(25'h0000001, 1'b0, 2'b01);
    wide_case(25'h1FFFFFF, 1'b1, 2'b00);
    wide_case(25'h0AAAAAA, 1'b1, 2'b10);
  endtask

  task automatic t_hold;
    logic e0, p0;
    do_reset(1'b0, 1'b0);
    wide_case(25'h1000000, 1'b0, 2'b01);
    e0 = err_n; p0 = ppar_out;
    step(25'h0000007, 1'b1, 2'b11);
    step(25'h0000003, 1'b0, 2'b11);
    check("R4 err_n held", err_n, e0);
    check("R4 ppar_out held", ppar_out, p0);
    check("R4 q held", q_out, 28'h1000000);
  endtask

  task automatic t_upper_ignored;
    do_reset(1'b0, 1'b1);
    wide_case(25'h0F0F0F1, 1'b0, 2'b10);
    check("R10 wide layout with cfg_upper set", err_n, !(^25'h0F0F0F1));
  endtask

  task automatic t_first;
    logic [24:0] d;
    do_reset(1'b1, 1'b0);
    d = 25'h1FFC001;
    step(d, 1'b0, 2'b10);
    check("R5 mirrored narrow capture", q_out, {d[13:0], d[13:0]});
    step(25'h0, 1'b0, 2'b11);
    check("R8 first device err_n stays high", err_n, 1);
    check("R8 ppar_out over narrow lanes", ppar_out, (^d[13:0]) ^ 1'b0);
    d = 25'h0003FFF;
    step(d, 1'b1, 2'b01);
    check("R5 upper input lanes ignored", q_out, {d[13:0], d[13:0]});
    step(25'h1555555, 1'b0, 2'b11);
    check("R7 ppar_out first device", ppar_out, (^d[13:0]) ^ 1'b1);
  endtask

  task automatic second_case(input logic [24:0] d, input logic pin, input logic prev);
    ppar_in = pin;
    step(d, ~pin, 2'b10);
    step(25'h0, 1'b0, 2'b11);
    check("R9 err_n not updated one cycle after capture", err_n, prev);
    step(25'h0, 1'b0, 2'b11);
    check("R9 second device final check", err_n, !((^d[13:0]) ^ pin));
  endtask

  task automatic t_second;
    do_reset(1'b1, 1'b1);
    second_case(25'h1FC0004, 1'b0, 1'b1);
    second_case(25'h0000004, 1'b1, 1'b0);
    second_case(25'h0000003, 1'b1, 1'b1);
  endtask

  initial begin
    @(negedge clk);
    t_wide;
    t_hold;
    t_upper_ignored;
    t_first;
    t_second;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule